// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This unit sits beside a cache and handles the cache's misses. A miss that no stream can serve goes to memory as a demand request. The unit then claims one of its stream buffers for the addresses that follow the missing block. That stream keeps fetching the next blocks in order, using memory cycles that demand traffic leaves free. The fetched blocks stay in the stream buffer and never enter the cache. On every later miss the unit compares the oldest entry of each stream with the requested block address. When that oldest entry matches and holds data, the block returns at once. The entry is removed, and the stream requests the block after its newest entry.

All addresses are block addresses. The miss input, the block return, the memory request and the memory response each use a valid/ready handshake:
- The miss input takes one request at a time. `miss_ready` stays low from acceptance until the returned block has been taken.
- `ret_valid` and its payload stay fixed until `ret_ready` is seen.
- A demand offer on the memory request port stays fixed until it is accepted. A prefetch offer that has not been accepted may be withdrawn or replaced.
- Memory may answer requests in any order. It must echo the request tag unchanged. The unit always accepts responses.

Top module: `seq_stream_prefetch`

## Requirements
- R1: After reset `miss_ready` is 1 and both `ret_valid` and `mem_req_valid` are 0, because no stream is active.
- R2: A miss that no stream head can serve issues one demand request for the miss address. The unit then returns that address with the data memory sent back, and `ret_from_stream` is 0.
- R3: A miss that claims a stream causes prefetches of miss+1 up to miss+DEPTH, in ascending order, after the demand request. A stream never holds more than DEPTH requested blocks.
- R4: A miss whose address equals a stream's oldest entry, with that entry's data present, returns that data with `ret_from_stream` at 1. No memory request is made for that address, and exactly one new prefetch is made, for the block after the stream's newest entry.
- R5: Only the oldest entry of each stream is compared. A miss matching a younger entry goes to memory as in R2.
- R6: A miss that no stream serves flushes the stream claimed longest ago and restarts it at miss+1. Its old blocks can no longer be returned.
- R7: A demand request has priority over prefetches at the memory port. While it waits for `mem_req_ready`, its address and tag stay stable, and it is the next request accepted.
- R8: A response to a prefetch issued before its stream was flushed is discarded. It never appears on the block return.
- R9: While `ret_valid` is 1 and `ret_ready` is 0, `ret_valid`, `ret_addr`, `ret_data` and `ret_from_stream` hold, and `miss_ready` stays 0.
- R10: A miss whose address equals a stream's oldest entry whose data has not yet arrived waits for that data. It then returns the data from the stream and makes no demand request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| miss_valid | input | 1 | Cache miss offered |
| miss_ready | output | 1 | Unit can take a miss |
| miss_addr | input | ADDR_W | Missing block address |
| ret_valid | output | 1 | Returned block valid |
| ret_ready | input | 1 | Cache takes the returned block |
| ret_addr | output | ADDR_W | Address of the returned block |
| ret_data | output | DATA_W | Returned block contents |
| ret_from_stream | output | 1 | 1 when served from a stream buffer |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Requested block address |
| mem_req_tag | output | TAG_W | Opaque tag, echoed by memory |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Always 1 |
| mem_rsp_tag | input | TAG_W | Tag of the answered request |
| mem_rsp_data | input | DATA_W | Block contents |

## Verification
A stream that has just freed a slot wants to prefetch at the same moment a new demand miss wants the memory port. The bench stalls `mem_req_ready` after a stream hit, so a prefetch offer is left pending. It then sends a miss that no stream serves. While the port is stalled, the offered address must change to the demand address and stay there. Once the port opens, the first accepted request must be the demand, with the new stream's prefetches after it.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_DREQ  = 3'd2,
    ST_DWAIT = 3'd3,
    ST_RET   = 3'd4
  } ssp_state_e;

endpackage

// File: rtl/ssp_stream_buf.sv
module ssp_stream_buf #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int EPOCH_W = 2,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              pop_i,
  input  logic              issue_i,
  input  logic              fill_i,
  input  logic [SLOT_W-1:0] fill_slot_i,
  input  logic [EPOCH_W-1:0] fill_epoch_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              head_ready_o,
  output logic              head_wait_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              want_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  output logic [SLOT_W-1:0] pf_slot_o,
  output logic [EPOCH_W-1:0] epoch_o
);

  logic              active_q;
  logic [ADDR_W-1:0] head_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] rd_q;
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  vld_nx;
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [EPOCH_W-1:0] ep_q;
  logic              fill_ok;

  assign fill_ok = fill_i && (fill_epoch_i == ep_q);

  always_comb begin
    vld_nx = vld_q;
    if (fill_ok) vld_nx[fill_slot_i] = 1'b1;
    if (pop_i)   vld_nx[rd_q] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      head_q   <= '0;
      cnt_q    <= '0;
      rd_q     <= '0;
      vld_q    <= '0;
      ep_q     <= '0;
    end else if (flush_i) begin
      active_q <= 1'b1;
      head_q   <= flush_addr_i;
      cnt_q    <= '0;
      rd_q     <= '0;
      vld_q    <= '0;
      ep_q     <= ep_q + 1'b1;
    end else begin
      vld_q <= vld_nx;
      cnt_q <= cnt_q + CNT_W'(issue_i) - CNT_W'(pop_i);
      if (pop_i) begin
        rd_q   <= rd_q + 1'b1;
        head_q <= head_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) slot_q[fill_slot_i] <= fill_data_i;
  end

  assign head_addr_o  = head_q;
  assign head_ready_o = (cnt_q != '0) && vld_q[rd_q];
  assign head_wait_o  = (cnt_q != '0) && !vld_q[rd_q];
  assign head_data_o  = slot_q[rd_q];
  assign want_o       = active_q && (cnt_q < CNT_W'(DEPTH));
  assign pf_addr_o    = head_q + ADDR_W'(cnt_q);
  assign pf_slot_o    = rd_q + SLOT_W'(cnt_q);
  assign epoch_o      = ep_q;

  // R4: the controller pops only a head whose data is present
  p_pop_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> head_ready_o);

  // R3: the arbiter grants only a stream with a free slot
  p_issue_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> (cnt_q < CNT_W'(DEPTH)));

  // R6: a flush leaves the stream empty
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0) && !head_ready_o && !head_wait_o);

  // R8: a fill from an older epoch changes no valid bit
  p_stale_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && (fill_epoch_i != ep_q) && !pop_i && !flush_i) |=> $stable(vld_q));

endmodule

// File: rtl/ssp_lookup.sv
module ssp_lookup #(
  parameter int NS     = 4,
  parameter int ADDR_W = 24,
  localparam int SID_W = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [NS-1:0][ADDR_W-1:0]  head_addr_i,
  input  logic [NS-1:0]              head_ready_i,
  input  logic [NS-1:0]              head_wait_i,
  output logic                       hit_o,
  output logic [SID_W-1:0]           hit_idx_o,
  output logic                       wait_o
);

  logic [NS-1:0] m_hit;
  logic [NS-1:0] m_wait;

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign m_hit[g]  = head_ready_i[g] && (head_addr_i[g] == req_addr_i);
    assign m_wait[g] = head_wait_i[g]  && (head_addr_i[g] == req_addr_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (m_hit[i]) hit_idx_o = SID_W'(i);
    end
  end

  assign hit_o  = |m_hit;
  assign wait_o = |m_wait;

endmodule

// File: rtl/ssp_pf_arbiter.sv
module ssp_pf_arbiter #(
  parameter int NS     = 4,
  localparam int SID_W = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    req_i,
  input  logic             advance_i,
  output logic             gnt_any_o,
  output logic [SID_W-1:0] gnt_idx_o
);

  logic [SID_W-1:0] ptr_q;

  always_comb begin : pick
    int k;
    gnt_any_o = 1'b0;
    gnt_idx_o = '0;
    for (int off = 0; off < NS; off++) begin
      k = int'(ptr_q) + off;
      if (k >= NS) k = k - NS;
      if (!gnt_any_o && req_i[k]) begin
        gnt_any_o = 1'b1;
        gnt_idx_o = SID_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance_i && gnt_any_o) begin
      ptr_q <= (int'(gnt_idx_o) == NS - 1) ? '0 : gnt_idx_o + 1'b1;
    end
  end

  // R3: a grant always goes to a requesting stream
  p_grant_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any_o |-> req_i[gnt_idx_o]);

endmodule

// File: rtl/seq_stream_prefetch.sv
module seq_stream_prefetch
  import ssp_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int NS      = 4,
  parameter int DEPTH   = 4,
  parameter int EPOCH_W = 2,
  localparam int SID_W  = (NS > 1) ? $clog2(NS) : 1,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int TAG_W  = 1 + SID_W + SLOT_W + EPOCH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [DATA_W-1:0] ret_data,
  output logic              ret_from_stream,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [TAG_W-1:0]  mem_req_tag,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [TAG_W-1:0]  mem_rsp_tag,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  ssp_state_e        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] ret_data_q;
  logic              ret_src_q;
  logic [SID_W-1:0]  vic_q;

  logic [NS-1:0][ADDR_W-1:0]  s_head;
  logic [NS-1:0][DATA_W-1:0]  s_data;
  logic [NS-1:0][ADDR_W-1:0]  s_pf_addr;
  logic [NS-1:0][SLOT_W-1:0]  s_pf_slot;
  logic [NS-1:0][EPOCH_W-1:0] s_epoch;
  logic [NS-1:0] s_ready, s_wait, s_want;
  logic [NS-1:0] s_pop, s_flush, s_issue, s_fill;

  logic             hit, wait_any;
  logic [SID_W-1:0] hit_idx;
  logic             pf_any;
  logic [SID_W-1:0] pf_idx;
  logic             look, pf_allowed, pf_accept, alloc;

  logic              rsp_dem;
  logic [SID_W-1:0]  rsp_sid;
  logic [SLOT_W-1:0] rsp_slot;
  logic [EPOCH_W-1:0] rsp_epoch;

  assign rsp_dem   = mem_rsp_tag[TAG_W-1];
  assign rsp_sid   = mem_rsp_tag[TAG_W-2 -: SID_W];
  assign rsp_slot  = mem_rsp_tag[EPOCH_W +: SLOT_W];
  assign rsp_epoch = mem_rsp_tag[EPOCH_W-1:0];

  ssp_lookup #(.NS(NS), .ADDR_W(ADDR_W)) u_lookup (
    .req_addr_i   (req_addr_q),
    .head_addr_i  (s_head),
    .head_ready_i (s_ready),
    .head_wait_i  (s_wait),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx),
    .wait_o       (wait_any)
  );

  ssp_pf_arbiter #(.NS(NS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (s_want),
    .advance_i (pf_accept),
    .gnt_any_o (pf_any),
    .gnt_idx_o (pf_idx)
  );

  assign look       = (state_q == ST_LOOK);
  assign alloc      = look && !hit && !wait_any;
  assign pf_allowed = (state_q != ST_LOOK) && (state_q != ST_DREQ);
  assign pf_accept  = pf_allowed && pf_any && mem_req_ready;

  for (genvar g = 0; g < NS; g++) begin : g_stream
    assign s_pop[g]   = look && hit && (hit_idx == SID_W'(g));
    assign s_flush[g] = alloc && (vic_q == SID_W'(g));
    assign s_issue[g] = pf_accept && (pf_idx == SID_W'(g));
    assign s_fill[g]  = mem_rsp_valid && !rsp_dem && (rsp_sid == SID_W'(g));

    ssp_stream_buf #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .EPOCH_W(EPOCH_W)
    ) u_sb (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (s_flush[g]),
      .flush_addr_i (req_addr_q + 1'b1),
      .pop_i        (s_pop[g]),
      .issue_i      (s_issue[g]),
      .fill_i       (s_fill[g]),
      .fill_slot_i  (rsp_slot),
      .fill_epoch_i (rsp_epoch),
      .fill_data_i  (mem_rsp_data),
      .head_addr_o  (s_head[g]),
      .head_ready_o (s_ready[g]),
      .head_wait_o  (s_wait[g]),
      .head_data_o  (s_data[g]),
      .want_o       (s_want[g]),
      .pf_addr_o    (s_pf_addr[g]),
      .pf_slot_o    (s_pf_slot[g]),
      .epoch_o      (s_epoch[g])
    );
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = req_addr_q;
    mem_req_tag   = {1'b1, {(TAG_W-1){1'b0}}};
    if (state_q == ST_DREQ) begin
      mem_req_valid = 1'b1;
    end else if (pf_allowed && pf_any) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = s_pf_addr[pf_idx];
      mem_req_tag   = {1'b0, pf_idx, s_pf_slot[pf_idx], s_epoch[pf_idx]};
    end
  end

  assign mem_rsp_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      req_addr_q <= '0;
      ret_data_q <= '0;
      ret_src_q  <= 1'b0;
      vic_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_valid) begin
          req_addr_q <= miss_addr;
          state_q    <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit) begin
            ret_data_q <= s_data[hit_idx];
            ret_src_q  <= 1'b1;
            state_q    <= ST_RET;
          end else if (!wait_any) begin
            vic_q   <= (int'(vic_q) == NS - 1) ? '0 : vic_q + 1'b1;
            state_q <= ST_DREQ;
          end
        end
        ST_DREQ: if (mem_req_ready) state_q <= ST_DWAIT;
        ST_DWAIT: if (mem_rsp_valid && rsp_dem) begin
          ret_data_q <= mem_rsp_data;
          ret_src_q  <= 1'b0;
          state_q    <= ST_RET;
        end
        ST_RET: if (ret_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign miss_ready      = (state_q == ST_IDLE);
  assign ret_valid       = (state_q == ST_RET);
  assign ret_addr        = req_addr_q;
  assign ret_data        = ret_data_q;
  assign ret_from_stream = ret_src_q;

  // R9: a stalled return holds its payload
  p_ret_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> ret_valid && $stable(ret_data) &&
      $stable(ret_addr) && $stable(ret_from_stream));

  // R7: a waiting demand offer is not withdrawn or altered
  p_dem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && mem_req_tag[TAG_W-1]) |=>
      mem_req_valid && mem_req_tag[TAG_W-1] && $stable(mem_req_addr));

  // R4: a stream-served return never coincides with a demand offer
  p_hit_no_dem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_from_stream) |-> !(mem_req_valid && mem_req_tag[TAG_W-1]));

  // R2: a memory-served return follows a demand response
  p_dem_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ret_valid) && !ret_from_stream) |-> $past(mem_rsp_valid && rsp_dem));

endmodule

// File: tb/seq_stream_prefetch_bench.sv
module seq_stream_prefetch_bench;

  localparam int AW  = 24;
  localparam int DW  = 32;
  localparam int TW  = 7;
  localparam int LAT = 2;
  localparam int LOGN = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic miss_ready;
  logic [AW-1:0] miss_addr = '0;
  logic ret_valid;
  logic ret_ready = 1'b1;
  logic [AW-1:0] ret_addr;
  logic [DW-1:0] ret_data;
  logic ret_from_stream;
  logic mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_ready;
  logic [TW-1:0] mem_rsp_tag = '0;
  logic [DW-1:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  seq_stream_prefetch u_seq_stream_prefetch (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_addr(ret_addr),
    .ret_data(ret_data), .ret_from_stream(ret_from_stream),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5a3c, a[15:0]};
  endfunction

  // memory model: any-order responses, address window can be held back
  logic [AW-1:0] m_addr [LOGN];
  logic [TW-1:0] m_tag  [LOGN];
  int            m_due  [LOGN];
  bit            m_done [LOGN];
  int m_n = 0;
  int cyc = 0;
  int sel = 0;
  bit hold_on = 1'b0;
  logic [AW-1:0] hold_lo = '0, hold_hi = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_valid && mem_req_ready && m_n < LOGN) begin
      m_addr[m_n] <= mem_req_addr;
      m_tag[m_n]  <= mem_req_tag;
      m_due[m_n]  <= cyc + LAT;
      m_done[m_n] <= 1'b0;
      m_n <= m_n + 1;
    end
    if (mem_rsp_valid && mem_rsp_ready) m_done[sel] <= 1'b1;
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    for (int i = 0; i < m_n; i++) begin
      if (!mem_rsp_valid && !m_done[i] && m_due[i] <= cyc &&
          !(hold_on && m_addr[i] >= hold_lo && m_addr[i] <= hold_hi)) begin
        mem_rsp_valid = 1'b1;
        sel = i;
        mem_rsp_tag = m_tag[i];
        mem_rsp_data = mdata(m_addr[i]);
      end
    end
  end

  task automatic check(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit logged_since(input logic [AW-1:0] a, input int from);
    for (int i = from; i < m_n; i++) if (m_addr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (25) @(negedge clk);
  endtask

  task automatic send_miss(input logic [AW-1:0] a);
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic wait_ret(output bit seen);
    int n = 0;
    seen = 1'b0;
    while (!ret_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    seen = ret_valid;
  endtask

  task automatic miss_expect(input string rq, input logic [AW-1:0] a,
                             input logic src);
    bit seen;
    send_miss(a);
    wait_ret(seen);
    check(rq, "return seen", 64'(seen), 64'd1);
    check(rq, "ret_addr", 64'(ret_addr), 64'(a));
    check(rq, "ret_data", 64'(ret_data), 64'(mdata(a)));
    check(rq, "ret_from_stream", 64'(ret_from_stream), 64'(src));
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1", "miss_ready", 64'(miss_ready), 64'd1);
    check("R1", "ret_valid", 64'(ret_valid), 64'd0);
    check("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_first_miss();
    int base = m_n;
    bit seen;
    logic [DW-1:0] d0;
    ret_ready = 1'b0;
    send_miss(24'h100);
    wait_ret(seen);
    check("R2", "return seen", 64'(seen), 64'd1);
    check("R2", "ret_data", 64'(ret_data), 64'(mdata(24'h100)));
    check("R2", "ret_from_stream", 64'(ret_from_stream), 64'd0);
    d0 = ret_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9", "ret_valid held", 64'(ret_valid), 64'd1);
      check("R9", "ret_data held", 64'(ret_data), 64'(d0));
      check("R9", "miss_ready low", 64'(miss_ready), 64'd0);
    end
    ret_ready = 1'b1;
    @(negedge clk);
    check("R9", "ret_valid drops", 64'(ret_valid), 64'd0);
    settle();
    check("R3", "request count", 64'(m_n - base), 64'd5);
    check("R2", "demand first", 64'(m_addr[base]), 64'h100);
    for (int k = 1; k <= 4; k++)
      check("R3", "prefetch order", 64'(m_addr[base + k]), 64'(24'h100 + k));
  endtask

  task automatic t_head_hit();
    int base = m_n;
    miss_expect("R4", 24'h101, 1'b1);
    settle();
    check("R4", "one new request", 64'(m_n - base), 64'd1);
    check("R4", "next prefetch", 64'(m_addr[base]), 64'h105);
    check("R4", "no demand", 64'(logged_since(24'h101, base)), 64'd0);
  endtask

  task automatic t_head_only();
    int base = m_n;
    miss_expect("R5", 24'h103, 1'b0);
    settle();
    check("R5", "demand to memory", 64'(m_addr[base]), 64'h103);
  endtask

  task automatic t_replace();
    miss_expect("R6", 24'h200, 1'b0);
    miss_expect("R6", 24'h300, 1'b0);
    miss_expect("R6", 24'h400, 1'b0);
    settle();
    miss_expect("R6", 24'h102, 1'b0);
    settle();
    miss_expect("R6", 24'h201, 1'b1);
    miss_expect("R6", 24'h401, 1'b1);
    settle();
  endtask

  task automatic t_priority();
    int base;
    bit seen;
    mem_req_ready = 1'b0;
    miss_expect("R7", 24'h202, 1'b1);
    check("R7", "prefetch offered", 64'(mem_req_valid), 64'd1);
    check("R7", "prefetch addr", 64'(mem_req_addr), 64'h206);
    base = m_n;
    send_miss(24'h900);
    repeat (3) @(negedge clk);
    check("R7", "demand offered", 64'(mem_req_valid), 64'd1);
    check("R7", "demand addr", 64'(mem_req_addr), 64'h900);
    mem_req_ready = 1'b1;
    wait_ret(seen);
    check("R7", "return seen", 64'(seen), 64'd1);
    check("R7", "first accepted", 64'(m_addr[base]), 64'h900);
    @(negedge clk);
    settle();
  endtask

  task automatic t_stale();
    do_reset();
    hold_lo = 24'h701;
    hold_hi = 24'h704;
    hold_on = 1'b1;
    miss_expect("R8", 24'h700, 1'b0);
    miss_expect("R8", 24'h800, 1'b0);
    miss_expect("R8", 24'h900, 1'b0);
    miss_expect("R8", 24'hA00, 1'b0);
    miss_expect("R8", 24'hB00, 1'b0);
    settle();
    hold_on = 1'b0;
    settle();
    miss_expect("R8", 24'hB01, 1'b1);
    miss_expect("R8", 24'h701, 1'b0);
    settle();
  endtask

  task automatic t_wait_head();
    int base;
    bit seen;
    hold_lo = 24'h601;
    hold_hi = 24'h601;
    hold_on = 1'b1;
    miss_expect("R10", 24'h600, 1'b0);
    settle();
    base = m_n;
    send_miss(24'h601);
    repeat (8) @(negedge clk);
    check("R10", "still waiting", 64'(ret_valid), 64'd0);
    check("R10", "miss_ready low", 64'(miss_ready), 64'd0);
    hold_on = 1'b0;
    wait_ret(seen);
    check("R10", "return seen", 64'(seen), 64'd1);
    check("R10", "ret_data", 64'(ret_data), 64'(mdata(24'h601)));
    check("R10", "ret_from_stream", 64'(ret_from_stream), 64'd1);
    check("R10", "no demand", 64'(logged_since(24'h601, base)), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    t_reset_state();
    t_first_miss();
    t_head_hit();
    t_head_only();
    t_replace();
    t_priority();
    t_stale();
    t_wait_head();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule